// File: doc/BRIEF.md
# Pipelined Modular Adder/Subtractor

This block returns either (a + b) mod p or (a − b) mod p for wide operands and a wide modulus. The caller must supply a and b already reduced, so that both lie in [0, p − 1]. A one-bit operation select travels with each input beat. The block can accept a fresh beat on every clock, with any mix of operations and moduli from one beat to the next. Each result appears a fixed number of cycles later, together with an output strobe.

Two adders are shared between the two operations.

- **First adder.** It forms a + b, or a + ~b + 1 when the select is set.
- **Second adder.** It forms S1 + ~p + 1 for addition, or S1 + p for subtraction.
- **Result choice.** The final result is either S1 or S2. The choice is made from the two carry-outs alone, so no magnitude comparator is needed.

Each adder is split at the half-word, and the carry is registered between the halves. This gives four register stages.

Top module: `modAddSub`

## Requirements
- R1: With inOp = 0 (addition) and a, b < p, the result equals (a + b) mod p and is always below p.
- R2: With inOp = 1 (subtraction) and a ≥ b, the result equals a − b; a zero b returns a unchanged.
- R3: Addition that reaches or passes p is reduced once. This covers a + b = p (result 0), a = b = p − 1 (result p − 2), and sums that carry out of the top bit of the operand width.
- R4: Subtraction with a < b returns a − b + p. Subtraction with a = b returns 0, and a = 0 with b = p − 1 returns 1.
- R5: outValid is high exactly 4 clock cycles after the cycle in which inValid was sampled high, and is low otherwise.
- R6: Inputs presented on consecutive cycles, with any mix of operations and moduli, produce results on consecutive cycles in the same order. Each result is independent of its neighbours.
- R7: A synchronous, active-high rst drops every in-flight operation. outValid stays low during reset and until a beat sampled after reset reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| inValid | input | 1 | Input beat strobe |
| inOp | input | 1 | 0 = modular addition, 1 = modular subtraction |
| inA | input | WIDTH (256) | First operand, in [0, inMod − 1] |
| inB | input | WIDTH (256) | Second operand, in [0, inMod − 1] |
| inMod | input | WIDTH (256) | Modulus |
| outValid | output | 1 | Result strobe |
| outResult | output | WIDTH (256) | Reduced sum or difference |

## Verification
The add path is tried with sums below p, exactly p, 2p − 2, and sums that overflow the operand width against a modulus close to 2^256. Together these separate the case where S1 is kept, the case where the second carry selects S2, and the case where only the first carry selects S2.

The subtract path is tried with a > b, a = b, a < b, a zero minuend and a zero subtrahend. These show whether the borrow case, and only the borrow case, adds p back.

Long back-to-back bursts of random operands under random odd moduli of varying size alternate the operation on every beat, so leakage between stages shows up as a wrong value. A reset issued while beats are in flight shows whether those beats are discarded.

// File: rtl/modAddSubPkg.sv
package modAddSubPkg;

  // Number of register stages from input sample to output.
  localparam int LATENCY = 4;

  // Per-stage load enables issued by the control to the datapath.
  typedef struct packed {
    logic [LATENCY-1:0] load;
  } stageStrobe_t;

endpackage

// File: rtl/modAddSubCtrl.sv
module modAddSubCtrl
  import modAddSubPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output stageStrobe_t strobe,
  output logic         outValid
);

  logic [LATENCY-1:0] vld;

  // Stage k loads when the beat ahead of it is valid.
  always_ff @(posedge clk) begin
    if (rst) vld[0] <= 1'b0;
    else     vld[0] <= inValid;
  end

  for (genvar k = 1; k < LATENCY; k++) begin : gShift
    always_ff @(posedge clk) begin
      if (rst) vld[k] <= 1'b0;
      else     vld[k] <= vld[k-1];
    end
  end

  assign strobe.load = {vld[LATENCY-2:0], inValid};
  assign outValid    = vld[LATENCY-1];

  // Cycles since reset, saturating, so the latency check only looks back
  // over cycles that followed reset.
  logic [2:0] sinceRst;
  always_ff @(posedge clk) begin
    if (rst)                          sinceRst <= '0;
    else if (sinceRst != 3'(LATENCY)) sinceRst <= sinceRst + 3'd1;
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 3'(LATENCY)) |-> (outValid == $past(inValid, LATENCY))); // R5

  AST_RESET_FLUSH: assert property (@(posedge clk)
    $past(rst) |-> !outValid); // R7

endmodule

// File: rtl/modAddSubPath.sv
module modAddSubPath
  import modAddSubPkg::*;
#(
  parameter int WIDTH = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  stageStrobe_t     strobe,
  input  logic             op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] p,
  output logic [WIDTH-1:0] result
);

  localparam int LO = WIDTH / 2;
  localparam int HI = WIDTH - LO;

  // ---- stage 1: low half of S1 = a + (b or ~b) + op
  logic [WIDTH-1:0] bEff;
  logic [LO:0]      s1LoSum;
  assign bEff    = op ? ~b : b;
  assign s1LoSum = {1'b0, a[LO-1:0]} + {1'b0, bEff[LO-1:0]} + {{LO{1'b0}}, op};

  logic [LO-1:0]    st1SumLo;
  logic             st1CarryLo;
  logic [HI-1:0]    st1AHi, st1BHi;
  logic [WIDTH-1:0] st1Mod;
  logic             st1Op;

  always_ff @(posedge clk) begin
    if (strobe.load[0]) begin
      st1SumLo   <= s1LoSum[LO-1:0];
      st1CarryLo <= s1LoSum[LO];
      st1AHi     <= a[WIDTH-1:LO];
      st1BHi     <= bEff[WIDTH-1:LO];
      st1Mod     <= p;
      st1Op      <= op;
    end
  end

  // ---- stage 2: high half of S1, giving carry c1
  logic [HI:0] s1HiSum;
  assign s1HiSum = {1'b0, st1AHi} + {1'b0, st1BHi} + {{HI{1'b0}}, st1CarryLo};

  logic [WIDTH-1:0] st2S1, st2Mod;
  logic             st2C1, st2Op;

  always_ff @(posedge clk) begin
    if (strobe.load[1]) begin
      st2S1  <= {s1HiSum[HI-1:0], st1SumLo};
      st2C1  <= s1HiSum[HI];
      st2Mod <= st1Mod;
      st2Op  <= st1Op;
    end
  end

  // ---- stage 3: low half of S2 = S1 + (~p + 1 for add, p for sub)
  logic [WIDTH-1:0] modEff;
  logic [LO:0]      s2LoSum;
  assign modEff  = st2Op ? st2Mod : ~st2Mod;
  assign s2LoSum = {1'b0, st2S1[LO-1:0]} + {1'b0, modEff[LO-1:0]} + {{LO{1'b0}}, ~st2Op};

  logic [WIDTH-1:0] st3S1, st3Mod;
  logic [LO-1:0]    st3S2Lo;
  logic             st3C1, st3CarryLo, st3Op;

  always_ff @(posedge clk) begin
    if (strobe.load[2]) begin
      st3S1      <= st2S1;
      st3C1      <= st2C1;
      st3S2Lo    <= s2LoSum[LO-1:0];
      st3CarryLo <= s2LoSum[LO];
      st3Mod     <= st2Mod;
      st3Op      <= st2Op;
    end
  end

  // ---- stage 4: high half of S2, carry c2, carry-driven choice
  logic [HI-1:0] modEffHi;
  logic [HI:0]   s2HiSum;
  logic          c2, takeS2;
  assign modEffHi = st3Op ? st3Mod[WIDTH-1:LO] : ~st3Mod[WIDTH-1:LO];
  assign s2HiSum  = {1'b0, st3S1[WIDTH-1:LO]} + {1'b0, modEffHi} + {{HI{1'b0}}, st3CarryLo};
  assign c2       = s2HiSum[HI];
  // add: reduce when a+b overflowed the width or S1 >= p
  // sub: add p back when no carry, i.e. a < b
  assign takeS2   = st3Op ? ~st3C1 : (st3C1 | c2);

  always_ff @(posedge clk) begin
    if (strobe.load[3])
      result <= takeS2 ? {s2HiSum[HI-1:0], st3S2Lo} : st3S1;
  end

  // With operands in range, an overflowing sum is below 2p, so S1 - p
  // cannot also carry.
  AST_ADD_SINGLE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (strobe.load[3] && !st3Op && st3C1) |-> !c2); // R3

  // A borrowed difference lies in (-p, 0), so adding p must carry out.
  AST_SUB_BORROW_FIX: assert property (@(posedge clk) disable iff (rst)
    (strobe.load[3] && st3Op && !st3C1) |-> c2); // R4

  AST_RESULT_REDUCED: assert property (@(posedge clk) disable iff (rst)
    strobe.load[3] |=> (result < $past(st3Mod))); // R1

endmodule

// File: rtl/modAddSub.sv
module modAddSub
  import modAddSubPkg::*;
#(
  parameter int WIDTH = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             inOp,
  input  logic [WIDTH-1:0] inA,
  input  logic [WIDTH-1:0] inB,
  input  logic [WIDTH-1:0] inMod,
  output logic             outValid,
  output logic [WIDTH-1:0] outResult
);

  stageStrobe_t strobe;

  modAddSubCtrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  modAddSubPath #(.WIDTH(WIDTH)) uPath (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .op     (inOp),
    .a      (inA),
    .b      (inB),
    .p      (inMod),
    .result (outResult)
  );

endmodule

// File: tb/modAddSub_test.sv
`timescale 1ns/1ps
module modAddSub_test;

  localparam int W = 256;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic         inOp = 1'b0;
  logic [W-1:0] inA = '0, inB = '0, inMod = 'd3;
  logic         outValid;
  logic [W-1:0] outResult;

  int    errors = 0;
  int    checks = 0;
  bit    checkOn = 1'b0;
  bit    finished = 1'b0;
  string curTag = "R1";
  string idleTag = "R5";

  always #2.5 clk = ~clk;

  modAddSub #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inOp(inOp),
    .inA(inA), .inB(inB), .inMod(inMod),
    .outValid(outValid), .outResult(outResult)
  );

  function automatic logic [W-1:0] refModel(input logic op, input logic [W-1:0] x, y, m);
    logic [W:0] s;
    if (!op) begin
      s = {1'b0, x} + {1'b0, y};
      if (s >= {1'b0, m}) s = s - {1'b0, m};
    end else if (x >= y) begin
      s = {1'b0, x} - {1'b0, y};
    end else begin
      s = {1'b0, x} + {1'b0, m} - {1'b0, y};
    end
    return s[W-1:0];
  endfunction

  function automatic logic [W-1:0] rnd256();
    logic [W-1:0] r = '0;
    for (int i = 0; i < 8; i++) r = {r[W-33:0], 32'($urandom())};
    return r;
  endfunction

  // Behavioural 4-slot model of the pipeline.
  logic         mv[4];
  logic [W-1:0] mr[4];
  string        mt[4];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) mv[i] = 1'b0;
    end else begin
      for (int i = 3; i > 0; i--) begin
        mv[i] = mv[i-1]; mr[i] = mr[i-1]; mt[i] = mt[i-1];
      end
      mv[0] = inValid;
      mr[0] = inValid ? refModel(inOp, inA, inB, inMod) : '0;
      mt[0] = curTag;
    end
  end

  always @(negedge clk) begin
    if (checkOn && !finished) begin
      checks++;
      if (outValid !== mv[3]) begin
        errors++;
        $display("FAIL %s: outValid actual=%b expected=%b", mv[3] ? mt[3] : idleTag, outValid, mv[3]);
      end
      if (mv[3]) begin
        checks++;
        if (outResult !== mr[3]) begin
          errors++;
          $display("FAIL %s: result actual=%h expected=%h", mt[3], outResult, mr[3]);
        end
      end
    end
  end

  task automatic send(input logic op, input logic [W-1:0] x, y, m, input string tag);
    @(negedge clk);
    inValid = 1'b1; inOp = op; inA = x; inB = y; inMod = m; curTag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  task automatic sendRandom(input logic op, input string tag);
    logic [W-1:0] m, x, y;
    m = (rnd256() >> $urandom_range(0, 250)) | 1;
    if (m < 3) m = 3;
    x = rnd256() % m;
    y = rnd256() % m;
    send(op, x, y, m, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pSmall, pBig;
    pSmall = 'd97;
    pBig   = {W{1'b1}} - 'd188;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkOn = 1'b1;   // R7: outValid low straight after reset

    // Addition, isolated beats (R1, R3, R5)
    send(0, 'd50, 'd30, pSmall, "R1"); idle(5);
    send(0, 'd0, 'd0, pSmall, "R1"); idle(5);
    send(0, 'd60, 'd50, pSmall, "R3"); idle(5);
    send(0, 'd40, 'd57, pSmall, "R3"); idle(5);
    send(0, pSmall - 1, pSmall - 1, pSmall, "R3"); idle(5);
    send(0, pBig - 1, pBig - 1, pBig, "R3"); idle(5);
    send(0, pBig - 1, 'd1, pBig, "R3"); idle(5);
    send(0, 'd0, pBig - 1, pBig, "R1"); idle(5);

    // Subtraction (R2, R4)
    send(1, 'd70, 'd20, pSmall, "R2"); idle(5);
    send(1, 'd33, 'd0, pSmall, "R2"); idle(5);
    send(1, 'd20, 'd70, pSmall, "R4"); idle(5);
    send(1, 'd44, 'd44, pSmall, "R4"); idle(5);
    send(1, 'd0, pSmall - 1, pSmall, "R4"); idle(5);
    send(1, 'd0, pBig - 1, pBig, "R4"); idle(5);
    send(1, pBig - 1, 'd0, pBig, "R2");

    // Back-to-back burst, alternating operations (R6)
    for (int i = 0; i < 300; i++) sendRandom(1'(i), "R6");
    for (int i = 0; i < 200; i++) sendRandom(1'($urandom_range(0, 1)), "R6");
    idle(6);

    // Random beats with random gaps (R1, R2, R5)
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 1) == 0) sendRandom(1'b0, "R1");
      else                           sendRandom(1'b1, "R2");
      idle($urandom_range(0, 3));
    end
    idle(6);

    // Reset with beats in flight (R7)
    idleTag = "R7";
    sendRandom(1'b0, "R7");
    sendRandom(1'b1, "R7");
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0; inValid = 1'b0;
    idle(6);
    idleTag = "R5";
    send(1, 'd5, 'd9, pSmall, "R7"); idle(6);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule